// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Timer Pair

This block holds two 8-bit up-counters, timer A and timer B, each compared against its own compare register. Software sets them up through a small byte-wide write port that reaches four registers: a control byte for each timer and a compare byte for each timer. A read port returns the same registers. All logic runs on one system clock. Count clocks are single-cycle enable pulses taken from a free-running prescaler: one pulse every 64 cycles and one every 256 cycles.

The operating mode is decoded from both control bytes together. In the separate, carrier and PWM modes the timers run independently. Timer B always counts the divide-by-64 pulse. Timer A counts one of four sources: either prescaler tap, timer B's match events, or the rising edges of a carrier square wave that toggles on every timer B match. In cascade mode the pair forms one 16-bit counter, with timer B as the low byte and timer A as the high byte. Timer B's enable then starts and stops both timers, and timer B's carry clocks timer A. A prohibited mode or clock code freezes the counters it affects and raises an error flag. The flag stays up until a valid code is written.

Top module: `dual_timer_pair`

## Requirements
- R1: After reset all four registers read 0x00, both counts are 0, and the match, interrupt, carrier and error outputs are low.
- R2: Register addresses are 0 = control A, 1 = control B, 2 = compare A, 3 = compare B. Control A holds enable in bit 7, clock select in bits 5:3 and mode in bits 2:1. Control B holds enable in bit 7 and mode in bits 2:1. Every other control bit is ignored on write and reads back 0.
- R3: An enabled timer B advances once every 64 system clocks. On a count pulse where its count equals compare B, it returns to 0 and raises matchB for exactly one cycle, so matches repeat every (compareB+1)*64 cycles.
- R4: Timer A clock select 000 counts once every 64 system clocks and 001 counts once every 256 system clocks. Timer A's match follows the same compare, clear and one-cycle-pulse rule as timer B.
- R5: Timer A clock select 010 counts timer B match events. With compare A = 0, matchA is high in the same cycle as every matchB.
- R6: The carrier output toggles on every timer B match. Clock select 011 counts the carrier's rising edges, which come on every second timer B match.
- R7: Clearing a timer's enable bit resets its count to 0 and holds it there.
- R8: The mode code {A bits 2:1, B bits 2:1} is valid only for 0000 (separate), 0101 (cascade), 0011 (carrier) and 0010 (PWM).
- R9: In cascade mode timer B is the low byte and timer A the high byte of one 16-bit count. Timer A increments when timer B wraps from 0xFF to 0x00. Only when both bytes equal their compares do both clear, with matchA and matchB high together. The period is (compareA*256+compareB+1)*64 cycles.
- R10: In cascade mode timer A's enable and clock select have no effect. Both timers run and clear under timer B's enable, and clock select codes 1xx raise no error.
- R11: Outside cascade mode, a clock select of 1xx sets errClk and freezes timer A's count. Writing a valid code clears errClk and counting resumes.
- R12: A prohibited mode code sets errMode and freezes both counts. Writing a valid code clears errMode.
- R13: irq is high for exactly one cycle for each cycle in which either match output is high. Coincident matches give a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| cntA | output | 8 | Timer A count |
| cntB | output | 8 | Timer B count |
| matchA | output | 1 | Timer A match pulse |
| matchB | output | 1 | Timer B match pulse |
| carrierOut | output | 1 | Carrier square wave, toggles per timer B match |
| irq | output | 1 | Interrupt pulse on any match |
| errClk | output | 1 | Prohibited timer A clock select flag |
| errMode | output | 1 | Prohibited mode code flag |

## Verification
Timer A's match and timer B's match can fall in the same cycle. Two settings force this: timer A counting timer B match events with compare A at zero, and cascade mode, where a full 16-bit match fires both outputs. At each detected timer B match the bench checks in that same cycle that matchA is also high and that irq is high. It then checks that irq is low one cycle later. Over a fixed window it compares the number of irq cycles with the number of match events, so two coincident matches must produce one pulse and not two.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;

  // Timer A count source, low two bits of its clock select field
  typedef enum logic [1:0] {
    SRC_DIV_LO  = 2'b00,
    SRC_DIV_HI  = 2'b01,
    SRC_B_MATCH = 2'b10,
    SRC_CARRIER = 2'b11
  } srcSel_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic    cascade;
    logic    runA;
    logic    clrA;
    logic    runB;
    logic    clrB;
    srcSel_e srcA;
  } tmrStrobe_t;

  localparam logic [1:0] ADDR_CTRL_A = 2'd0;
  localparam logic [1:0] ADDR_CTRL_B = 2'd1;
  localparam logic [1:0] ADDR_CMP_A  = 2'd2;
  localparam logic [1:0] ADDR_CMP_B  = 2'd3;

  localparam logic [7:0] CTRL_A_MASK = 8'hBE;
  localparam logic [7:0] CTRL_B_MASK = 8'h86;

  localparam logic [3:0] MODE_SEPARATE = 4'b0000;
  localparam logic [3:0] MODE_CASCADE  = 4'b0101;
  localparam logic [3:0] MODE_CARRIER  = 4'b0011;
  localparam logic [3:0] MODE_PWM      = 4'b0010;

endpackage

// File: rtl/timer_pair_ctrl.sv
module timer_pair_ctrl
  import timer_pair_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] cmpA,
  output logic [CNT_W-1:0] cmpB,
  output tmrStrobe_t       strobe,
  output logic             errClk,
  output logic             errMode
);

  logic [7:0] ctrlA;
  logic [7:0] ctrlB;

  // Register file; reserved control bits are masked on write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlA <= '0;
      ctrlB <= '0;
      cmpA  <= '0;
      cmpB  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL_A: ctrlA <= wrData[7:0] & CTRL_A_MASK;
        ADDR_CTRL_B: ctrlB <= wrData[7:0] & CTRL_B_MASK;
        ADDR_CMP_A:  cmpA  <= wrData;
        default:     cmpB  <= wrData;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL_A: rdData[7:0] = ctrlA;
      ADDR_CTRL_B: rdData[7:0] = ctrlB;
      ADDR_CMP_A:  rdData      = cmpA;
      default:     rdData      = cmpB;
    endcase
  end

  // Field views
  logic       enA, enB;
  logic [2:0] selA;
  logic [3:0] modeCode;
  assign enA      = ctrlA[7];
  assign enB      = ctrlB[7];
  assign selA     = ctrlA[5:3];
  assign modeCode = {ctrlA[2:1], ctrlB[2:1]};

  logic modeOk, isCascade, clkOk, clkBad;

  always_comb begin
    modeOk    = 1'b0;
    isCascade = 1'b0;
    case (modeCode)
      MODE_SEPARATE, MODE_CARRIER, MODE_PWM: modeOk = 1'b1;
      MODE_CASCADE: begin
        modeOk    = 1'b1;
        isCascade = 1'b1;
      end
      default: ;
    endcase
  end

  assign clkOk  = ~selA[2];
  assign clkBad = ~isCascade & ~clkOk;

  always_comb begin
    strobe.cascade = isCascade;
    strobe.runB    = modeOk & enB;
    strobe.clrB    = modeOk & ~enB;
    strobe.srcA    = srcSel_e'(selA[1:0]);
    if (isCascade) begin
      strobe.runA = enB;
      strobe.clrA = ~enB;
    end else begin
      strobe.runA = modeOk & clkOk & enA;
      strobe.clrA = modeOk & clkOk & ~enA;
    end
  end

  // Error flags follow register contents; they stay set until a valid code is written
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errClk  <= 1'b0;
      errMode <= 1'b0;
    end else begin
      errClk  <= clkBad;
      errMode <= ~modeOk;
    end
  end

endmodule

// File: rtl/timer_pair_dp.sv
module timer_pair_dp
  import timer_pair_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_LO_LOG2 = 6,
  parameter int PRE_HI_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  output logic [CNT_W-1:0] cntA,
  output logic [CNT_W-1:0] cntB,
  output logic             matchA,
  output logic             matchB,
  output logic             carrier
);

  // Free-running prescaler producing single-cycle tap pulses
  logic [PRE_HI_LOG2-1:0] preCnt;
  logic tickLo, tickHi;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  assign tickLo = &preCnt[PRE_LO_LOG2-1:0];
  assign tickHi = &preCnt;

  logic tickB, hitA, hitB, evB, carrierRise, srcTick, tickA, casHit, wrapB;

  assign tickB       = strobe.runB & tickLo;
  assign hitA        = (cntA == cmpA);
  assign hitB        = (cntB == cmpB);
  assign evB         = tickB & hitB;
  assign carrierRise = evB & ~carrier;
  assign casHit      = hitA & hitB;
  assign wrapB       = &cntB;

  always_comb begin
    case (strobe.srcA)
      SRC_DIV_LO:  srcTick = tickLo;
      SRC_DIV_HI:  srcTick = tickHi;
      SRC_B_MATCH: srcTick = evB;
      default:     srcTick = carrierRise;
    endcase
  end

  assign tickA = strobe.runA & srcTick;

  // Timer B (low byte in cascade) and the carrier
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntB    <= '0;
      matchB  <= 1'b0;
      carrier <= 1'b0;
    end else begin
      matchB <= 1'b0;
      if (strobe.clrB) begin
        cntB    <= '0;
        carrier <= 1'b0;
      end else if (tickB) begin
        if (strobe.cascade ? casHit : hitB) begin
          cntB    <= '0;
          matchB  <= 1'b1;
          carrier <= ~carrier;
        end else begin
          cntB <= cntB + 1'b1;
        end
      end
    end
  end

  // Timer A (high byte in cascade)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntA   <= '0;
      matchA <= 1'b0;
    end else begin
      matchA <= 1'b0;
      if (strobe.cascade) begin
        if (strobe.clrB) begin
          cntA <= '0;
        end else if (tickB) begin
          if (casHit) begin
            cntA   <= '0;
            matchA <= 1'b1;
          end else if (wrapB) begin
            cntA <= cntA + 1'b1;
          end
        end
      end else if (strobe.clrA) begin
        cntA <= '0;
      end else if (tickA) begin
        if (hitA) begin
          cntA   <= '0;
          matchA <= 1'b1;
        end else begin
          cntA <= cntA + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dual_timer_pair.sv
module dual_timer_pair
  import timer_pair_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_LO_LOG2 = 6,
  parameter int PRE_HI_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] cntA,
  output logic [CNT_W-1:0] cntB,
  output logic             matchA,
  output logic             matchB,
  output logic             carrierOut,
  output logic             irq,
  output logic             errClk,
  output logic             errMode
);

  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] cmpA, cmpB;

  timer_pair_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .cmpA(cmpA), .cmpB(cmpB),
    .strobe(strobe),
    .errClk(errClk), .errMode(errMode)
  );

  timer_pair_dp #(
    .CNT_W(CNT_W), .PRE_LO_LOG2(PRE_LO_LOG2), .PRE_HI_LOG2(PRE_HI_LOG2)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe),
    .cmpA(cmpA), .cmpB(cmpB),
    .cntA(cntA), .cntB(cntB),
    .matchA(matchA), .matchB(matchB),
    .carrier(carrierOut)
  );

  assign irq = matchA | matchB;

endmodule

// File: rtl/timer_pair_chk.sv
module timer_pair_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cascadeOn,
  input logic             clrAOn,
  input logic [CNT_W-1:0] cntA,
  input logic [CNT_W-1:0] cntB,
  input logic             matchA,
  input logic             matchB,
  input logic             irq,
  input logic             errClk,
  input logic             errMode
);

  // R3
  match_b_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchB |=> !matchB);

  // R4
  match_a_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchA |=> !matchA);

  // R13
  irq_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchA || matchB) |-> irq);

  // R13
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R9
  cascade_joint_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cascadeOn && matchB) |-> matchA);

  // R7
  clear_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrAOn |=> (cntA == '0));

  // R12
  mode_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    errMode |-> ($stable(cntA) && $stable(cntB)));

  // R11
  clk_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errClk && !cascadeOn) |-> $stable(cntA));

endmodule

bind dual_timer_pair timer_pair_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN),
  .cascadeOn(strobe.cascade), .clrAOn(strobe.clrA),
  .cntA(cntA), .cntB(cntB),
  .matchA(matchA), .matchB(matchB), .irq(irq),
  .errClk(errClk), .errMode(errMode)
);

// File: tb/tb_dual_timer_pair.sv
module tb_dual_timer_pair;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData, cntA, cntB;
  logic       matchA, matchB, carrierOut, irq, errClk, errMode;

  dual_timer_pair dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cntA(cntA), .cntB(cntB),
    .matchA(matchA), .matchB(matchB), .carrierOut(carrierOut), .irq(irq),
    .errClk(errClk), .errMode(errMode)
  );

  always #5 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] aByte(input bit en, input logic [2:0] sel, input logic [1:0] mode);
    return {en, 1'b0, sel, mode, 1'b0};
  endfunction

  function automatic logic [7:0] bByte(input bit en, input logic [1:0] mode);
    return {en, 4'b0000, mode, 1'b0};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic idle();
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    repeat (2) @(negedge clk);
  endtask

  task automatic waitPulse(input bit onA, input int limit, output longint t, output bit ok);
    ok = 1'b0; t = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (onA ? matchA : matchB) begin
        ok = 1'b1; t = cyc; break;
      end
    end
  endtask

  task automatic periodChk(input bit onA, input longint expP, input string req);
    longint t1, t2; bit ok1, ok2;
    waitPulse(onA, int'(expP) * 2 + 1000, t1, ok1);
    waitPulse(onA, int'(expP) + 1000, t2, ok2);
    check(ok1 && ok2 && (t2 - t1) == expP, req, t2 - t1, expP);
  endtask

  task automatic testReset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 8'h00, "R1 register reset", d, 0);
    end
    check(cntA == 0 && cntB == 0, "R1 counts reset", {cntA, cntB}, 0);
    check({matchA, matchB, irq, carrierOut, errClk, errMode} == 6'b0, "R1 outputs reset",
          {matchA, matchB, irq, carrierOut, errClk, errMode}, 0);
  endtask

  task automatic testRegMap();
    logic [7:0] d;
    wr(2'd0, 8'hFF); rd(2'd0, d); check(d == 8'hBE, "R2 control A reserved bits", d, 8'hBE);
    wr(2'd1, 8'hFF); rd(2'd1, d); check(d == 8'h86, "R2 control B reserved bits", d, 8'h86);
    wr(2'd2, 8'h5A); rd(2'd2, d); check(d == 8'h5A, "R2 compare A", d, 8'h5A);
    wr(2'd3, 8'hA5); rd(2'd3, d); check(d == 8'hA5, "R2 compare B", d, 8'hA5);
    idle();
  endtask

  task automatic testTimerB();
    longint t; bit ok;
    wr(2'd3, 8'd3);
    wr(2'd1, bByte(1, 2'b00));
    periodChk(1'b0, 256, "R3 timer B period");
    waitPulse(1'b0, 1000, t, ok);
    @(negedge clk);
    check(ok && !matchB, "R3 matchB one cycle", matchB, 0);
    idle();
  endtask

  task automatic testClkA();
    wr(2'd2, 8'd2);
    wr(2'd1, bByte(0, 2'b10));
    wr(2'd0, aByte(1, 3'b000, 2'b00));
    periodChk(1'b1, 192, "R4 timer A div64 period");
    check(errMode == 0, "R8 PWM code valid", errMode, 0);
    idle();
    wr(2'd2, 8'd1);
    wr(2'd0, aByte(1, 3'b001, 2'b00));
    periodChk(1'b1, 512, "R4 timer A div256 period");
    idle();
  endtask

  task automatic testBMatchSrc();
    longint t; bit ok;
    wr(2'd3, 8'd3);
    wr(2'd2, 8'd0);
    wr(2'd1, bByte(1, 2'b00));
    wr(2'd0, aByte(1, 3'b010, 2'b00));
    waitPulse(1'b0, 2000, t, ok);
    waitPulse(1'b0, 2000, t, ok);
    check(ok && matchA, "R5 matchA coincides with matchB", matchA, 1);
    check(irq, "R13 irq on coincident match", irq, 1);
    @(negedge clk);
    check(!irq, "R13 coincident irq one cycle", irq, 0);
    periodChk(1'b1, 256, "R5 timer A on B matches, compare 0");
    wr(2'd2, 8'd1);
    periodChk(1'b1, 512, "R5 timer A on B matches, compare 1");
    idle();
  endtask

  task automatic testCarrier();
    longint t; bit ok; logic c1, c2;
    wr(2'd3, 8'd3);
    wr(2'd2, 8'd0);
    wr(2'd1, bByte(1, 2'b11));
    wr(2'd0, aByte(1, 3'b011, 2'b00));
    waitPulse(1'b0, 2000, t, ok); c1 = carrierOut;
    waitPulse(1'b0, 2000, t, ok); c2 = carrierOut;
    check(ok && c1 != c2, "R6 carrier toggles per B match", c2, !c1);
    periodChk(1'b1, 512, "R6 timer A on carrier edges");
    check(errMode == 0, "R8 carrier code valid", errMode, 0);
    idle();
  endtask

  task automatic testEnableClear();
    wr(2'd3, 8'd200);
    wr(2'd1, bByte(1, 2'b00));
    repeat (600) @(negedge clk);
    check(cntB != 0, "R7 timer B running", cntB, 1);
    wr(2'd1, bByte(0, 2'b00));
    @(negedge clk);
    check(cntB == 0, "R7 disable clears count", cntB, 0);
    repeat (300) @(negedge clk);
    check(cntB == 0, "R7 disabled count held at 0", cntB, 0);
    idle();
  endtask

  task automatic testCascade();
    longint t; bit ok; bit seen;
    wr(2'd2, 8'd1);
    wr(2'd3, 8'd2);
    wr(2'd0, aByte(0, 3'b111, 2'b01));
    wr(2'd1, bByte(1, 2'b01));
    repeat (2) @(negedge clk);
    check(errClk == 0 && errMode == 0, "R10 cascade ignores clock select", {errClk, errMode}, 0);
    seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (cntA == 1) begin seen = 1'b1; break; end
    end
    check(seen && cntB == 0, "R9 high byte steps on low byte wrap", cntB, 0);
    waitPulse(1'b0, 20000, t, ok);
    check(ok && matchA && cntA == 0 && cntB == 0, "R9 joint match clears both",
          {matchA, cntA, cntB}, 9'h100);
    periodChk(1'b0, 16576, "R9 cascade period");
    wr(2'd0, aByte(1, 3'b111, 2'b01));
    wr(2'd1, bByte(0, 2'b01));
    @(negedge clk);
    repeat (400) @(negedge clk);
    check(cntA == 0 && cntB == 0 && !matchA && !matchB, "R10 timer A enable ignored in cascade",
          {cntA, cntB}, 0);
    idle();
  endtask

  task automatic testClkErr();
    logic [7:0] snap;
    wr(2'd2, 8'd200);
    wr(2'd0, aByte(1, 3'b000, 2'b00));
    repeat (500) @(negedge clk);
    wr(2'd0, aByte(1, 3'b100, 2'b00));
    @(negedge clk);
    check(errClk == 1, "R11 prohibited clock flagged", errClk, 1);
    snap = cntA;
    check(snap != 0, "R11 count nonzero before freeze", snap, 1);
    repeat (300) @(negedge clk);
    check(cntA == snap, "R11 timer A frozen", cntA, snap);
    wr(2'd0, aByte(1, 3'b000, 2'b00));
    @(negedge clk);
    check(errClk == 0, "R11 valid code clears flag", errClk, 0);
    repeat (300) @(negedge clk);
    check(cntA > snap, "R11 counting resumes", cntA, snap + 1);
    idle();
  endtask

  task automatic testModeErr();
    logic [7:0] sa, sb;
    wr(2'd2, 8'd200);
    wr(2'd3, 8'd200);
    wr(2'd1, bByte(1, 2'b00));
    wr(2'd0, aByte(1, 3'b000, 2'b00));
    repeat (500) @(negedge clk);
    wr(2'd0, aByte(1, 3'b000, 2'b01));
    @(negedge clk);
    check(errMode == 1, "R8 code 0100 prohibited", errMode, 1);
    sa = cntA; sb = cntB;
    repeat (300) @(negedge clk);
    check(cntA == sa && cntB == sb && sb != 0, "R12 both timers frozen", {cntA, cntB}, {sa, sb});
    wr(2'd0, aByte(1, 3'b000, 2'b00));
    @(negedge clk);
    check(errMode == 0, "R12 valid code clears flag", errMode, 0);
    idle();
  endtask

  task automatic testIrq();
    int nIrq, nB, nOrphan;
    nIrq = 0; nB = 0; nOrphan = 0;
    wr(2'd3, 8'd1);
    wr(2'd2, 8'd0);
    wr(2'd1, bByte(1, 2'b00));
    wr(2'd0, aByte(1, 3'b010, 2'b00));
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      if (irq) nIrq++;
      if (matchB) nB++;
      if (irq && !matchA && !matchB) nOrphan++;
    end
    check(nIrq == nB && nB >= 7, "R13 one irq cycle per coincident match", nIrq, nB);
    check(nOrphan == 0, "R13 irq only with a match", nOrphan, 0);
    idle();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegMap();
    testTimerB();
    testClkA();
    testBMatchSrc();
    testCarrier();
    testEnableClear();
    testCascade();
    testClkErr();
    testModeErr();
    testIrq();
    summary();
    $finish;
  end

endmodule